// File: doc/BRIEF.md
# TDM Frame Deserializer with Holding Register

This block sits on the receive side of a time-division multiplexed serial link. A frame holds a fixed number of timeslots, and each timeslot carries one byte. The block gets one data bit per clock, together with a frame strobe. The strobe is high on the final bit of every frame. The block runs a local position counter. The low field of that counter holds the bit index within a timeslot, and the high field holds the timeslot index. The strobe aligns this counter to the transmitter.

Each incoming bit enters a serial-in, parallel-out register, most significant bit first. When the counter shows that the last bit of a timeslot has arrived, the complete byte goes into a holding register. The holding register is tagged with its timeslot number and a single-cycle valid strobe. Downstream logic reads a steady byte for a whole timeslot, while the shift register contents change on every clock. Clock recovery, line decoding and undoing any zero-byte substitution are handled elsewhere.

Top module: `tdm_frame_rx`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rx_valid` is 0, and `rx_byte`, `rx_slot` and `shift_word` are all zero.
- R2: A clock edge that samples `frame_sync` high makes the next sampled bit bit 0 of timeslot 0. The byte completed 8 clocks later is reported with `rx_slot` = 0.
- R3: On every clock edge out of reset, `shift_word` becomes its previous value shifted one place toward the MSB, with the sampled `ser_data` entering at bit 0.
- R4: Within a timeslot, the first bit received lands in bit 7 of the captured byte and the last bit lands in bit 0.
- R5: When the edge samples the last bit of a timeslot (bit index 7 in the aligned counter), `rx_byte` takes the completed byte on that edge, equal to the new `shift_word`, and `rx_valid` is 1 for the following cycle.
- R6: Without a strobe, the counter advances by one per clock. Captured timeslots are numbered 0, 1, … 31 and then wrap to 0.
- R7: In every cycle where `rx_valid` is 0, `rx_byte` and `rx_slot` keep their previous values.
- R8: After reset, `rx_valid` stays 0 until the first `frame_sync` has been sampled.
- R9: A strobe in the middle of a frame re-aligns the counter at once. Captures then follow the new alignment, so the next capture comes 8 clocks later with `rx_slot` = 0.
- R10: `rx_valid` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_data | input | 1 | Serial data bit, sampled on each rising edge |
| frame_sync | input | 1 | High on the final bit of a frame |
| shift_word | output | 8 | Live contents of the serial-in shift register |
| rx_byte | output | 8 | Holding register: last completed byte |
| rx_slot | output | 5 | Timeslot number of `rx_byte` |
| rx_valid | output | 1 | Single-cycle strobe when the holding register is loaded |

## Verification
The bench builds the block with its defaults: 8 bits per timeslot and 32 timeslots, which gives a 256-position counter. With these sizes, whole frames run in a few hundred clocks. The bench can therefore check the timeslot wrap from 31 to 0, several strobe-aligned frames in a row, and a strobe that arrives partway through a frame. The reference model gets the same two-field layout from the same two numbers. Every byte value the bench sees therefore comes from the bit order and the counter arithmetic alone.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  // Default frame geometry: bits per timeslot and timeslots per frame.
  localparam int unsigned DEF_SLOT_BITS = 8;
  localparam int unsigned DEF_NUM_SLOTS = 32;
endpackage

// File: rtl/tdm_rx_slot_counter.sv
module tdm_rx_slot_counter #(
  parameter int unsigned SLOT_BITS = tdm_rx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = tdm_rx_pkg::DEF_NUM_SLOTS,
  localparam int unsigned BW = $clog2(SLOT_BITS),
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned CW = BW + SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_sync,
  output logic [SW-1:0] cur_slot,
  output logic          locked,
  output logic          last_bit
);
  logic [CW-1:0] cnt_q;

  // Next position: a strobe forces all zeros, otherwise step by one.
  function automatic logic [CW-1:0] step_pos(input logic [CW-1:0] c, input logic strobe);
    return strobe ? '0 : c + {{(CW-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic ends_slot(input logic [CW-1:0] c);
    return c[BW-1:0] == BW'(SLOT_BITS - 1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      locked <= 1'b0;
    end else begin
      cnt_q <= step_pos(cnt_q, frame_sync);
      if (frame_sync) locked <= 1'b1;
    end
  end

  assign cur_slot = cnt_q[CW-1:BW];
  assign last_bit = locked && ends_slot(cnt_q);

  // R2: the strobe zeroes the position counter
  p_sync_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt_q == '0));
  // R6: without a strobe the counter steps by one, wrapping at the frame end
  p_count_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_sync |=> (cnt_q == $past(cnt_q) + {{(CW-1){1'b0}}, 1'b1}));
  // R8: lock only comes from a strobe
  p_lock_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(frame_sync));
endmodule

// File: rtl/tdm_rx_sipo.sv
module tdm_rx_sipo #(
  parameter int unsigned W = tdm_rx_pkg::DEF_SLOT_BITS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         din,
  output logic [W-1:0] word_q,
  output logic [W-1:0] word_next
);
  // MSB-first: older bits move toward the top, the new bit enters at bit 0.
  function automatic logic [W-1:0] shift_in(input logic [W-1:0] w, input logic b);
    return {w[W-2:0], b};
  endfunction

  assign word_next = shift_in(word_q, din);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_next;
  end

  // R3: one bit enters per clock, the rest move up one place
  p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (word_q[0] == $past(din)) && (word_q[W-1:1] == $past(word_q[W-2:0])));
endmodule

// File: rtl/tdm_rx_hold.sv
module tdm_rx_hold #(
  parameter int unsigned W  = tdm_rx_pkg::DEF_SLOT_BITS,
  parameter int unsigned SW = $clog2(tdm_rx_pkg::DEF_NUM_SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [W-1:0]  byte_in,
  input  logic [SW-1:0] slot_in,
  output logic [W-1:0]  byte_q,
  output logic [SW-1:0] slot_q,
  output logic          valid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      slot_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) begin
        byte_q <= byte_in;
        slot_q <= slot_in;
      end
    end
  end

  // R7: the holding register only moves together with a valid strobe
  p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_q |-> ($stable(byte_q) && $stable(slot_q)));
  // R10: the strobe lasts a single cycle
  p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx #(
  parameter int unsigned SLOT_BITS = tdm_rx_pkg::DEF_SLOT_BITS,
  parameter int unsigned NUM_SLOTS = tdm_rx_pkg::DEF_NUM_SLOTS,
  localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ser_data,
  input  logic                 frame_sync,
  output logic [SLOT_BITS-1:0] shift_word,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic [SW-1:0]        rx_slot,
  output logic                 rx_valid
);
  logic [SW-1:0]        cur_slot;
  logic                 locked;
  logic                 byte_done;
  logic [SLOT_BITS-1:0] word_next;

  tdm_rx_slot_counter #(.SLOT_BITS(SLOT_BITS), .NUM_SLOTS(NUM_SLOTS)) i_cnt (
    .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
    .cur_slot(cur_slot), .locked(locked), .last_bit(byte_done)
  );

  tdm_rx_sipo #(.W(SLOT_BITS)) i_sipo (
    .clk(clk), .rst_n(rst_n), .din(ser_data),
    .word_q(shift_word), .word_next(word_next)
  );

  tdm_rx_hold #(.W(SLOT_BITS), .SW(SW)) i_hold (
    .clk(clk), .rst_n(rst_n), .capture(byte_done),
    .byte_in(word_next), .slot_in(cur_slot),
    .byte_q(rx_byte), .slot_q(rx_slot), .valid_q(rx_valid)
  );

  // R8: no strobe before the first frame strobe
  p_no_valid_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !rx_valid);
  // R5: a fresh capture equals the byte now in the shift register
  p_capture_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (rx_byte == shift_word));
endmodule

// File: tb/test_tdm_frame_rx.sv
module test_tdm_frame_rx;
  localparam int SB = 8;
  localparam int NS = 32;
  localparam int FRAME = SB * NS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_data = 1'b0;
  logic frame_sync = 1'b0;
  logic [7:0] shift_word, rx_byte;
  logic [4:0] rx_slot;
  logic rx_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  bit cmp_on = 0;

  // reference model state
  int m_pos = 0, m_shift = 0, m_byte = 0, m_slot = 0;
  bit m_lock = 0, m_valid = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  tdm_frame_rx i_tdm_frame_rx (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .frame_sync(frame_sync),
    .shift_word(shift_word), .rx_byte(rx_byte), .rx_slot(rx_slot), .rx_valid(rx_valid)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pos = 0; m_lock = 0; m_shift = 0; m_byte = 0; m_slot = 0; m_valid = 0;
    end else begin
      m_shift = ((m_shift * 2) + int'(ser_data)) % 256;
      m_valid = m_lock && ((m_pos % SB) == SB - 1);
      if (m_valid) begin
        m_byte = m_shift;
        m_slot = m_pos / SB;
      end
      if (frame_sync) begin m_pos = 0; m_lock = 1; end
      else m_pos = (m_pos + 1) % FRAME;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk(rx_valid == m_valid, m_lock ? "R5/R10 valid" : "R8 valid before sync",
          int'(rx_valid), int'(m_valid));
      chk(int'(shift_word) == m_shift, "R3 shift", int'(shift_word), m_shift);
      chk(int'(rx_byte) == m_byte, m_valid ? "R4 byte" : "R7 byte hold",
          int'(rx_byte), m_byte);
      chk(int'(rx_slot) == m_slot, (m_slot == 0) ? "R2 slot" : "R6 slot",
          int'(rx_slot), m_slot);
    end
  end

  task automatic drive(input bit d, input bit s);
    @(negedge clk);
    ser_data = d;
    frame_sync = s;
  endtask

  function automatic bit pick(input int kind, input int pos);
    int v;
    case (kind)
      0: v = 0;
      1: v = ((pos / SB) * 37 + 11) % 256;
      default: v = 255;
    endcase
    return bit'((v >> (SB - 1 - (pos % SB))) & 1);
  endfunction

  task automatic send_frame(input int kind, input int upto);
    for (int p = 0; p < upto; p++) begin
      bit d;
      if (kind == 0) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        d = lfsr[0];
      end else d = pick(kind, p);
      drive(d, (p == upto - 1));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rx_valid == 1'b0, "R1 valid", int'(rx_valid), 0);
    chk(rx_byte == 8'd0, "R1 byte", int'(rx_byte), 0);
    chk(rx_slot == 5'd0, "R1 slot", int'(rx_slot), 0);
    chk(shift_word == 8'd0, "R1 shift", int'(shift_word), 0);
    rst_n = 1'b1;
    cmp_on = 1;
    // R8: free-running bits without any strobe
    for (int i = 0; i < 40; i++) drive(bit'(i % 3 == 0), 1'b0);
    drive(1'b1, 1'b1);            // first strobe aligns the counter
    send_frame(0, FRAME);
    send_frame(1, FRAME);
    send_frame(2, FRAME);
    send_frame(0, 100);           // R9: strobe partway through a frame
    send_frame(1, FRAME);
    send_frame(0, FRAME);
    drive(1'b0, 1'b0);
    @(negedge clk);
    @(posedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule